// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small stock of instruction bytes ready for a decoder. It asks a 16-bit memory port for code words, using a code segment base and a 16-bit fetch pointer. It stores the returned bytes in a six-entry first-in-first-out queue, and the decoder takes them out one byte at a time. Fetching and draining run at the same time, so the decoder can consume bytes while the next words are on their way.

Words go in and bytes come out. A new word fetch starts only when the queue has room for two more bytes and no earlier reply is still due. A fetch that starts at an odd pointer delivers only the upper byte of its word. When control flow changes, a flush with a new pointer empties the queue. It also throws away any reply still in flight, and fetching restarts at the new pointer.

The memory side is a plain request/valid exchange. `fetch_req` is a one-cycle request with `fetch_addr`. The reply comes later as a one-cycle `mem_rvalid` with the full word on `mem_rdata`. Replies return in request order, and at most one request is in flight at a time.

Top module: `prefetch_queue`

## Requirements
- R1: While `rst_n` is low at a rising edge, the queue empties: `byte_count` is 0, `byte_valid` is 0 and `fetch_req` is 0. After reset the fetch pointer is 0.
- R2: Bytes leave in ascending pointer order, with no gaps and no repeats. For an even-address word, the byte on `mem_rdata[7:0]` leaves before the byte on `mem_rdata[15:8]`.
- R3: `fetch_addr` equals the code segment base shifted left by 4, plus the fetch pointer, truncated to 20 bits. The fetch pointer itself wraps modulo 2^16.
- R4: `fetch_req` is raised only when the queue has at least 2 free slots and no reply is outstanding. The queue never holds more than 6 bytes. With an even start pointer and no pops, it settles at 6 bytes with `fetch_req` low.
- R5: A fetch issued from an odd pointer stores only `mem_rdata[15:8]` and advances the pointer by 1. Every fetch from an even pointer stores two bytes and advances it by 2. With an odd start and no pops, the queue therefore settles at 5 bytes.
- R6: A cycle with `flush` high empties the queue: `byte_count` is 0 after that edge. A reply that was outstanding at the flush is dropped when it arrives. The next fetch uses `flush_ptr`, and no request is raised in the flush cycle itself.
- R7: A `byte_pop` while the queue is empty changes nothing. A pop in the same cycle as a reply that stores n bytes changes the count by n-1.
- R8: `byte_count` reports the number of stored bytes (0 to 6). `byte_valid` is high exactly when that count is nonzero, and `byte_out` is then the oldest byte.
- R9: When the consumer pops on every valid cycle and memory answers one cycle after a request, 16 bytes drain within 40 cycles of the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_base | input | 16 | Code segment base value |
| flush | input | 1 | Discard queue contents and restart at `flush_ptr` |
| flush_ptr | input | 16 | New fetch pointer loaded by `flush` |
| fetch_req | output | 1 | One-cycle word fetch request |
| fetch_addr | output | 20 | Physical byte address of the fetch |
| mem_rvalid | input | 1 | Reply word valid this cycle |
| mem_rdata | input | 16 | Reply word, even-address byte in bits 7:0 |
| byte_valid | output | 1 | Queue holds at least one byte |
| byte_out | output | 8 | Oldest stored byte |
| byte_pop | input | 1 | Consume the oldest byte |
| byte_count | output | 3 | Number of bytes stored, 0 to 6 |

## Verification
Each result has a known due cycle:
- `fetch_req` and `fetch_addr` are combinational from registered state, so they are valid in the same cycle as the state that causes them.
- A reply sampled at a rising edge shows up in `byte_count` and `byte_out` right after that edge.
- A pop or a flush takes effect at the edge where it is sampled.

The bench drives every input and samples every output at the falling edge. The memory model looks at `fetch_req` shortly after the falling edge and answers at a falling edge a set number of cycles later. Count and byte checks are therefore made one half cycle after the edge that was meant to update them. The flush-over-pending case holds the flush until the model has a reply in flight, so that a stale word arrives after the flush.

// File: rtl/pfq_pkg.sv
// Package: shared widths and types for the prefetch byte queue.
// Assumes a 16-bit memory word made of two 8-bit lanes, with the lower
// lane holding the even address.
package pfq_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // Bytes handed from the reply path to the storage in one cycle.
    typedef struct packed {
        logic [1:0] cnt;     // 0, 1 or 2 bytes
        byte_t      first;   // written first (older)
        byte_t      second;  // written second, used when cnt == 2
    } push_t;

endpackage

// File: rtl/pfq_ptr_gen.sv
// Module: pfq_ptr_gen
// Holds the 16-bit fetch pointer and forms the 20-bit physical fetch
// address from the code segment base. The pointer loads on flush and,
// when a fetch is taken, steps by 1 from an odd value and by 2 from an
// even one. Assumes flush has priority over advance.
module pfq_ptr_gen #(
    parameter int PTR_W     = 16,
    parameter int SEG_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  seg_base,
    input  logic              load,
    input  logic [PTR_W-1:0]  load_ptr,
    input  logic              advance,
    output logic              ptr_odd,
    output logic [ADDR_W-1:0] phys_addr
);

    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  step;
    logic [ADDR_W-1:0] seg_part;
    logic [ADDR_W-1:0] off_part;

    // Step size: an odd pointer realigns with a single byte.
    always_comb begin
        step = ptr_q[0] ? PTR_W'(1) : PTR_W'(2);
    end

    // Physical address: shifted segment plus pointer, modulo 2^ADDR_W.
    always_comb begin
        seg_part  = ADDR_W'(seg_base) << SEG_SHIFT;
        off_part  = ADDR_W'(ptr_q);
        phys_addr = seg_part + off_part;
    end

    assign ptr_odd = ptr_q[0];

    // Pointer register: reset to zero, load on flush, step on fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_ptr;
        end else if (advance) begin
            ptr_q <= ptr_q + step;
        end
    end

    // R6: a flush makes the loaded pointer the next fetch pointer.
    a_r6_flush_loads_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr_q == $past(load_ptr)));

    // R5: a fetch from an odd pointer leaves the pointer even.
    a_r5_odd_realigns: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && ptr_q[0]) |=> !ptr_q[0]);

endmodule

// File: rtl/pfq_req_ctrl.sv
// Module: pfq_req_ctrl
// Decides when to issue a word fetch and turns replies into byte pushes.
// Only one request may be in flight. A flush turns an in-flight request
// stale, and its reply is then dropped. Assumes memory answers requests
// in order with exactly one mem_rvalid per request.
module pfq_req_ctrl
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CNT_W-1:0] count,
    input  logic             ptr_odd,
    input  logic             mem_rvalid,
    input  word_t            mem_rdata,
    output logic             fetch_req,
    output push_t            push
);

    localparam int FREE_W = CNT_W + 1;

    logic              pending_q;   // reply owed to the live stream
    logic              stale_q;     // reply owed to a flushed stream
    logic              single_q;    // in-flight request wants upper lane only
    logic [FREE_W-1:0] free_slots;
    logic              reply_live;

    // Free space in the queue.
    always_comb begin
        free_slots = FREE_W'(DEPTH) - FREE_W'(count);
    end

    // Fetch issue: room for a full word, nothing in flight, not flushing.
    always_comb begin
        fetch_req = rst_n && !flush && !pending_q && !stale_q
                    && (free_slots >= FREE_W'(2));
    end

    // Reply routing: odd fetches keep the upper lane only.
    always_comb begin
        reply_live  = mem_rvalid && pending_q && !flush;
        push.cnt    = 2'd0;
        push.first  = mem_rdata[BYTE_W-1:0];
        push.second = mem_rdata[WORD_W-1:BYTE_W];
        if (reply_live) begin
            if (single_q) begin
                push.cnt   = 2'd1;
                push.first = mem_rdata[WORD_W-1:BYTE_W];
            end else begin
                push.cnt   = 2'd2;
            end
        end
    end

    // In-flight tracking: set on issue, clear on reply, go stale on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            stale_q   <= 1'b0;
            single_q  <= 1'b0;
        end else if (flush) begin
            pending_q <= 1'b0;
            stale_q   <= (pending_q || stale_q) && !mem_rvalid;
        end else begin
            if (mem_rvalid) begin
                pending_q <= 1'b0;
                stale_q   <= 1'b0;
            end
            if (fetch_req) begin
                pending_q <= 1'b1;
                single_q  <= ptr_odd;
            end
        end
    end

    // R4: a request is never followed directly by another one.
    a_r4_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R6: a reply belonging to a flushed stream stores nothing.
    a_r6_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (stale_q && mem_rvalid) |-> (push.cnt == 2'd0));

endmodule

// File: rtl/pfq_byte_store.sv
// Module: pfq_byte_store
// Circular byte storage of DEPTH slots. It takes up to two bytes a cycle
// and releases one. A pop while empty is ignored, and clear empties it.
// Assumes the caller never pushes more bytes than there are free slots.
module pfq_byte_store
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  push_t            push,
    input  logic             pop,
    output byte_t            head,
    output logic [CNT_W-1:0] count
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] wr_idx_nxt;
    logic [CNT_W-1:0] count_q;
    logic             pop_ok;
    byte_t            slot_q [DEPTH];

    // Index step modulo DEPTH.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] idx,
                                              input logic [1:0] by);
        logic [IDX_W:0] sum;
        sum = {1'b0, idx} + (IDX_W+1)'(by);
        if (sum >= (IDX_W+1)'(DEPTH)) begin
            sum = sum - (IDX_W+1)'(DEPTH);
        end
        return sum[IDX_W-1:0];
    endfunction

    // Pop qualification: only a non-empty queue outside a clear pops.
    always_comb begin
        pop_ok     = pop && (count_q != '0) && !clear;
        wr_idx_nxt = bump(wr_idx, 2'd1);
    end

    // One register per slot, written by the first or second push byte.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        byte_t q;
        // Slot write: first byte at wr_idx, second at the next index.
        always_ff @(posedge clk) begin
            if (!clear && push.cnt != 2'd0 && wr_idx == IDX_W'(g)) begin
                q <= push.first;
            end else if (!clear && push.cnt == 2'd2 && wr_idx_nxt == IDX_W'(g)) begin
                q <= push.second;
            end
        end
        assign slot_q[g] = q;
    end

    // Indices and occupancy: clear resets all, otherwise push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_idx  <= '0;
            wr_idx  <= '0;
            count_q <= '0;
        end else begin
            wr_idx  <= bump(wr_idx, push.cnt);
            rd_idx  <= bump(rd_idx, {1'b0, pop_ok});
            count_q <= count_q + CNT_W'(push.cnt) - CNT_W'(pop_ok);
        end
    end

    assign head  = slot_q[rd_idx];
    assign count = count_q;

    // R4: storage never reports more than DEPTH bytes.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R7: a pop into an empty queue with no push leaves it empty.
    a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && pop && push.cnt == 2'd0 && !clear) |=> (count_q == '0));

    // R6: a clear leaves the queue empty on the next cycle.
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0));

endmodule

// File: rtl/prefetch_queue.sv
// Module: prefetch_queue
// Top of the instruction prefetch byte queue. It joins the pointer and
// address generator, the fetch and reply controller and the byte
// storage. Assumes one memory reply per request, returned in order.
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 6,
    parameter int PTR_W     = 16,
    parameter int SEG_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20,
    parameter int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  cs_base,
    input  logic              flush,
    input  logic [PTR_W-1:0]  flush_ptr,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_out,
    input  logic              byte_pop,
    output logic [CNT_W-1:0]  byte_count
);

    logic  ptr_odd;
    push_t push;

    pfq_ptr_gen #(
        .PTR_W    (PTR_W),
        .SEG_W    (SEG_W),
        .SEG_SHIFT(SEG_SHIFT),
        .ADDR_W   (ADDR_W)
    ) u_ptr_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .seg_base (cs_base),
        .load     (flush),
        .load_ptr (flush_ptr),
        .advance  (fetch_req),
        .ptr_odd  (ptr_odd),
        .phys_addr(fetch_addr)
    );

    pfq_req_ctrl #(
        .DEPTH(DEPTH),
        .CNT_W(CNT_W)
    ) u_req_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .count     (byte_count),
        .ptr_odd   (ptr_odd),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .fetch_req (fetch_req),
        .push      (push)
    );

    pfq_byte_store #(
        .DEPTH(DEPTH),
        .CNT_W(CNT_W)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(flush),
        .push (push),
        .pop  (byte_pop),
        .head (byte_out),
        .count(byte_count)
    );

    // Consumer view: a byte is offered whenever storage is non-empty.
    always_comb begin
        byte_valid = (byte_count != '0);
    end

endmodule

// File: tb/prefetch_queue_bench.sv
// Bench for prefetch_queue: a vector table walked by one loop, then
// directed tests for reset, fill limits, empty pops and flushes.
module prefetch_queue_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cs_base = 16'h0000;
    logic        flush = 1'b0;
    logic [15:0] flush_ptr = 16'h0000;
    logic        fetch_req;
    logic [19:0] fetch_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = 16'h0000;
    logic        byte_valid;
    logic [7:0]  byte_out;
    logic        byte_pop = 1'b0;
    logic [2:0]  byte_count;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prefetch_queue u_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .cs_base(cs_base), .flush(flush),
        .flush_ptr(flush_ptr), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .byte_valid(byte_valid),
        .byte_out(byte_out), .byte_pop(byte_pop), .byte_count(byte_count)
    );

    typedef struct packed {
        logic [15:0] cs;
        logic [15:0] ptr;
        logic [7:0]  nbytes;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h1000, 16'h0000, 8'd16, 4'd1},
        '{16'h2345, 16'h0011, 8'd13, 4'd2},
        '{16'hF000, 16'hFFFE, 8'd10, 4'd3},
        '{16'hFFFF, 16'h0021, 8'd9,  4'd1},
        '{16'h0123, 16'h7FFF, 8'd12, 4'd4},
        '{16'h0000, 16'h0002, 8'd20, 4'd2}
    };

    function automatic logic [7:0] memb(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] cs, input logic [15:0] p);
        return {cs, 4'h0} + {4'h0, p};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Memory model: answers each request lat cycles later.
    int          lat = 1;
    int          cd = 0;
    bit          pend = 0;
    logic [19:0] rsp_addr = '0;
    logic [15:0] exp_fptr = 16'h0000;   // expected pointer of the next fetch
    logic [15:0] exp_cptr = 16'h0000;   // expected pointer of the next byte out

    initial begin
        forever begin
            @(negedge clk);
            #1;
            mem_rvalid = 1'b0;
            if (pend) begin
                cd--;
                if (cd <= 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = {memb(rsp_addr | 20'h1), memb(rsp_addr & ~20'h1)};
                    pend = 0;
                end
            end
            if (fetch_req && rst_n) begin
                // R3: address built from segment and pointer
                chk(fetch_addr == phys(cs_base, exp_fptr), "R3 fetch address",
                    32'(fetch_addr), 32'(phys(cs_base, exp_fptr)));
                chk(!pend, "R4 request while reply due", 32'(pend), 0);
                rsp_addr = fetch_addr;
                pend = 1;
                cd = lat;
                exp_fptr = exp_fptr + (exp_fptr[0] ? 16'd1 : 16'd2);
            end
        end
    end

    task automatic do_flush(input logic [15:0] p);
        @(negedge clk);
        flush = 1'b1;
        flush_ptr = p;
        exp_fptr = p;
        exp_cptr = p;
        @(negedge clk);
        flush = 1'b0;
        chk(byte_count == 3'd0, "R6 count after flush", 32'(byte_count), 0);
        chk(!byte_valid, "R8 valid after flush", 32'(byte_valid), 0);
    endtask

    task automatic drain(input int n, input int gap, output int cycles);
        int got = 0;
        cycles = 0;
        for (int guard = 0; guard < 2000 && got < n; guard++) begin
            @(negedge clk);
            byte_pop = 1'b0;
            cycles++;
            if (byte_valid && (guard % (gap + 1)) == 0) begin
                chk(byte_out == memb(phys(cs_base, exp_cptr)), "R2 byte order",
                    32'(byte_out), 32'(memb(phys(cs_base, exp_cptr))));
                byte_pop = 1'b1;
                exp_cptr++;
                got++;
            end
        end
        @(negedge clk);
        byte_pop = 1'b0;
        chk(got == n, "R2 drain completed", got, n);
    endtask

    task automatic pop_one(input string tag);
        @(negedge clk);
        chk(byte_valid && byte_out == memb(phys(cs_base, exp_cptr)), tag,
            32'(byte_out), 32'(memb(phys(cs_base, exp_cptr))));
        byte_pop = 1'b1;
        exp_cptr++;
        @(negedge clk);
        byte_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(byte_count == 3'd0, "R1 count in reset", 32'(byte_count), 0);
        chk(!byte_valid, "R1 valid in reset", 32'(byte_valid), 0);
        chk(!fetch_req, "R1 no request in reset", 32'(fetch_req), 0);
        rst_n = 1'b1;

        // Vector table: segment, start pointer, bytes to drain, latency
        foreach (VECS[i]) begin
            lat = int'(VECS[i].lat);
            cs_base = VECS[i].cs;
            do_flush(VECS[i].ptr);
            drain(int'(VECS[i].nbytes), i % 3, cyc);
            if (i == 0) begin
                // R9: fetch overlaps draining
                chk(cyc <= 40, "R9 drain throughput", cyc, 40);
            end
        end

        // R4: even start without pops fills to six
        lat = 1;
        cs_base = 16'h0400;
        do_flush(16'h0010);
        repeat (30) @(negedge clk);
        chk(byte_count == 3'd6, "R4 full at six", 32'(byte_count), 6);
        chk(!fetch_req, "R4 no request when full", 32'(fetch_req), 0);
        chk(byte_valid, "R8 valid when full", 32'(byte_valid), 1);
        drain(6, 0, cyc);

        // R5: odd start without pops settles at five
        do_flush(16'h0105);
        repeat (30) @(negedge clk);
        chk(byte_count == 3'd5, "R5 odd start settles at five", 32'(byte_count), 5);
        chk(!fetch_req, "R5 no request with one slot free", 32'(fetch_req), 0);

        // R7: pop, then a pop meeting a two-byte reply: 5-1+2-1 = 5
        pop_one("R7 first pop byte");
        pop_one("R7 pop with push byte");
        repeat (10) @(negedge clk);
        chk(byte_count == 3'd5, "R7 count after push and pop", 32'(byte_count), 5);
        drain(8, 1, cyc);

        // R7: pop on empty queue is ignored
        lat = 5;
        do_flush(16'h0200);
        byte_pop = 1'b1;
        @(negedge clk);
        byte_pop = 1'b0;
        chk(byte_count == 3'd0, "R7 empty pop ignored", 32'(byte_count), 0);
        for (int g = 0; g < 50 && !byte_valid; g++) @(negedge clk);
        chk(byte_count == 3'd2, "R8 count after first word", 32'(byte_count), 2);
        chk(byte_out == memb(phys(cs_base, exp_cptr)), "R7 head after empty pop",
            32'(byte_out), 32'(memb(phys(cs_base, exp_cptr))));

        // R6: flush while a reply is outstanding drops that reply
        lat = 4;
        do_flush(16'h0040);
        for (int g = 0; g < 50 && !pend; g++) @(negedge clk);
        do_flush(16'h0203);
        drain(9, 0, cyc);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule